// File: doc/BRIEF.md
# Serial Receive Line Break, Idle and Edge Monitor

This block sits beside a serial receiver and watches the receive line after it has been sampled. It does not recover characters. It reports three events and keeps each one as a sticky flag:

- a break, which is a long run of low bit times;
- an idle character, which is a full character length of high bit times;
- a falling edge on the line.

The line is optionally inverted before any of this detection. A bit-time tick from the receiver's baud logic marks the one clock in each bit time in which the line level counts.

The break threshold is picked from a small table. The table is indexed by the character length mode, the stop-bit count and a long/short select. Idle counting has two variants:

- counting begins right after the start bit, so high data and stop bits count toward idle;
- counting begins only once the whole frame, stop bits included, has passed.

A receiver in standby can be told to stay silent about idle characters. Software clears each flag by pulsing its clear input. Each flag drives an interrupt request through its own enable.

Top module: `brk_idle_mon`

## Requirements
- R1: Every detection uses the effective line, which is `rx_sample` XOR `rx_invert`. With `rx_invert`=1, a raw high level counts as low.
- R2: With `brk_long`=0, `brk_flag` sets on the tick that completes a run of N consecutive low ticks. The table index is chosen by priority:
  - N=13 when `mode_ten`=1 and `two_stop`=1;
  - otherwise N=12 when `mode_ten`=1, or when `mode_nine`=1 and `two_stop`=1;
  - otherwise N=11 when `mode_nine`=1 or `two_stop`=1;
  - otherwise N=10.
  After N-1 low ticks the flag is still 0.
- R3: With `brk_long`=1 the same four cases use N=11, 12, 14 and 15.
- R4: The character length L is 1 + D + S. D is 10 when `mode_ten`=1, 9 when `mode_nine`=1, and 8 otherwise. S is 2 when `two_stop`=1 and 1 otherwise. With `idle_after_stop`=0, every high tick counts toward idle, and `idle_flag` sets on the tick that completes L consecutive counted high ticks while the receiver is active.
- R5: With `idle_after_stop`=1, high ticks inside the frame are not counted. The frame is the L ticks that follow the falling edge which started it. Only high ticks after the frame count.
- R6: While `standby`=1 and `standby_idle_en`=0, an idle character does not set `idle_flag`. It still ends the active state.
- R7: `rx_active` rises one clock after a falling edge of the effective line. It falls one clock after the tick that completes an idle character. It is 0 while waiting for a start bit.
- R8: `edge_flag` sets one clock after any falling edge of the effective line.
- R9: Each flag stays set until its clear input is 1 at a clock edge. If a new event arrives in the same cycle as the clear, the flag stays set.
- R10: `brk_irq`, `idle_irq` and `edge_irq` are each 1 exactly when the matching flag and its enable are both 1.
- R11: After reset all flags, `rx_active` and all interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_sample | input | 1 | Sampled receive line |
| bit_tick | input | 1 | One-clock pulse marking the bit-time sample point |
| mode_nine | input | 1 | Nine data bits per character |
| mode_ten | input | 1 | Ten data bits per character (overrides nine) |
| two_stop | input | 1 | Two stop bits |
| brk_long | input | 1 | Use the longer break threshold table |
| idle_after_stop | input | 1 | Idle counting starts after the stop bit(s) |
| rx_invert | input | 1 | Invert the receive line |
| standby | input | 1 | Receiver is in standby |
| standby_idle_en | input | 1 | Allow idle reporting during standby |
| brk_irq_en | input | 1 | Break interrupt enable |
| idle_irq_en | input | 1 | Idle interrupt enable |
| edge_irq_en | input | 1 | Edge interrupt enable |
| clr_brk | input | 1 | Clear break flag |
| clr_idle | input | 1 | Clear idle flag |
| clr_edge | input | 1 | Clear edge flag |
| brk_flag | output | 1 | Sticky break flag |
| idle_flag | output | 1 | Sticky idle flag |
| edge_flag | output | 1 | Sticky falling-edge flag |
| rx_active | output | 1 | Receiver active status |
| brk_irq | output | 1 | Break interrupt request |
| idle_irq | output | 1 | Idle interrupt request |
| edge_irq | output | 1 | Edge interrupt request |

## Verification
Timing of each result:
- `edge_flag` and the rise of `rx_active` are due on the first clock edge after the effective line falls, because one register lies on each path.
- `brk_flag` and `idle_flag` are due on the clock edge that carries the qualifying tick.
- The fall of `rx_active` comes on the same edge as `idle_flag`.
- The interrupt requests follow their flags and enables with no register.

The bench drives inputs on falling clock edges and compares all outputs with its reference model one time unit after each falling edge, so every registered result has settled. Directed checks sample right after the bit in which the tick fell. Each threshold case is checked one bit before the event and on the event bit.

// File: rtl/brk_idle_pkg.sv
// Package: shared length type and the mode-dependent length functions for the
// break/idle monitor. Assumes all lengths fit in four bits (max 15).
package brk_idle_pkg;

    localparam int LEN_W = 4;
    typedef logic [LEN_W-1:0] len_t;

    // Table row chosen by character mode and stop-bit count.
    function automatic logic [1:0] brk_row(input logic m9, input logic m10, input logic two);
        if (m10)            return two ? 2'd3 : 2'd2;
        else if (m9 && two) return 2'd2;
        else if (m9 || two) return 2'd1;
        else                return 2'd0;
    endfunction

    // Break threshold in bit times for a table row and length select.
    function automatic len_t brk_limit(input logic [1:0] row, input logic long_sel);
        len_t base;
        base = len_t'(row) + len_t'(10);
        if (long_sel) return base + len_t'(1) + ((row >= 2'd2) ? len_t'(1) : len_t'(0));
        else          return base;
    endfunction

    // Full character length: start + data + stop bits.
    function automatic len_t char_len(input logic m9, input logic m10, input logic two);
        len_t data_bits;
        data_bits = m10 ? len_t'(10) : (m9 ? len_t'(9) : len_t'(8));
        return len_t'(1) + data_bits + (two ? len_t'(2) : len_t'(1));
    endfunction

endpackage

// File: rtl/brk_line_cond.sv
// Line conditioner: applies optional inversion and flags falling edges of the
// resulting effective line. Assumes rx_sample is already synchronised.
module brk_line_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_sample,
    input  logic rx_invert,
    output logic eff_line,
    output logic fall_evt
);
    logic prev_q;

    assign eff_line = rx_sample ^ rx_invert;
    assign fall_evt = prev_q & ~eff_line;

    // Remember the previous effective level; idle-high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= eff_line;
    end
endmodule

// File: rtl/brk_run_counter.sv
// Run counter: counts consecutive ticks on which the line matches a level,
// resetting on a tick with the other level. Ticks that match but are not
// qualified neither count nor reset. hit pulses on the tick that makes the
// run equal to limit. Assumes limit < 2**W.
module brk_run_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         match,
    input  logic         qualify,
    input  logic [W-1:0] limit,
    output logic         hit
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;

    assign hit = tick & match & qualify & ({1'b0, cnt_q} + 1'b1 == {1'b0, limit});

    // Track the current run length, saturating at the counter maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (!match)                          cnt_q <= '0;
            else if (qualify && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/brk_frame_tracker.sv
// Frame tracker: holds the receiver-active state and the bit position within
// the current frame. A falling edge starts a frame only when idle or once the
// previous frame is complete. An idle hit ends the active state.
module brk_frame_tracker #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         fall_evt,
    input  logic         idle_hit,
    input  logic [W-1:0] frame_len,
    output logic         active,
    output logic         frame_done
);
    logic [W-1:0] pos_q;
    logic         start;

    assign frame_done = (pos_q >= frame_len);
    assign start      = fall_evt & (~active | frame_done);

    // Start, advance and end frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            pos_q  <= '0;
        end else if (start) begin
            active <= 1'b1;
            pos_q  <= '0;
        end else if (idle_hit) begin
            active <= 1'b0;
        end else if (tick && active && !frame_done) begin
            pos_q  <= pos_q + 1'b1;
        end
    end
endmodule

// File: rtl/brk_flag_bank.sv
// Flag bank: N sticky flags with clear-on-pulse, where a set in the same cycle
// wins over the clear. Each flag drives an interrupt request gated by its enable.
module brk_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_evt,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] irq_en,
    output logic [N-1:0] flag,
    output logic [N-1:0] irq
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // Hold one flag; a new event beats a simultaneous clear.
        always_ff @(posedge clk) begin
            if (!rst_n) flag[g] <= 1'b0;
            else        flag[g] <= set_evt[g] | (flag[g] & ~clr[g]);
        end
        assign irq[g] = flag[g] & irq_en[g];
    end
endmodule

// File: rtl/brk_idle_mon.sv
// Break/idle/edge monitor top. It conditions the line, counts low and high
// runs against mode-dependent limits, tracks the frame and feeds a sticky
// flag bank. Assumes bit_tick is one clock long and that ticks do not share a
// cycle with line transitions. Mode inputs are held steady while a character
// is in flight.
module brk_idle_mon
    import brk_idle_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_sample,
    input  logic bit_tick,
    input  logic mode_nine,
    input  logic mode_ten,
    input  logic two_stop,
    input  logic brk_long,
    input  logic idle_after_stop,
    input  logic rx_invert,
    input  logic standby,
    input  logic standby_idle_en,
    input  logic brk_irq_en,
    input  logic idle_irq_en,
    input  logic edge_irq_en,
    input  logic clr_brk,
    input  logic clr_idle,
    input  logic clr_edge,
    output logic brk_flag,
    output logic idle_flag,
    output logic edge_flag,
    output logic rx_active,
    output logic brk_irq,
    output logic idle_irq,
    output logic edge_irq
);
    localparam int NFLAG    = 3;
    localparam int IDX_BRK  = 0;
    localparam int IDX_IDLE = 1;
    localparam int IDX_EDGE = 2;

    logic             eff_line, fall_evt;
    len_t             brk_len, frm_len;
    logic             brk_hit, high_hit, idle_hit, frame_done, high_qual;
    logic             idle_report;
    logic [NFLAG-1:0] set_v, clr_v, en_v, flag_v, irq_v;

    assign brk_len = brk_limit(brk_row(mode_nine, mode_ten, two_stop), brk_long);
    assign frm_len = char_len(mode_nine, mode_ten, two_stop);

    brk_line_cond u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_sample(rx_sample),
        .rx_invert(rx_invert),
        .eff_line (eff_line),
        .fall_evt (fall_evt)
    );

    brk_run_counter #(.W(CNT_W)) u_low_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (bit_tick),
        .match  (~eff_line),
        .qualify(1'b1),
        .limit  (CNT_W'(brk_len)),
        .hit    (brk_hit)
    );

    // High ticks count anywhere, or only after the frame in after-stop mode.
    assign high_qual = ~idle_after_stop | frame_done;

    brk_run_counter #(.W(CNT_W)) u_high_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (bit_tick),
        .match  (eff_line),
        .qualify(high_qual),
        .limit  (CNT_W'(frm_len)),
        .hit    (high_hit)
    );

    assign idle_hit = high_hit & rx_active;

    brk_frame_tracker #(.W(LEN_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_tick),
        .fall_evt  (fall_evt),
        .idle_hit  (idle_hit),
        .frame_len (frm_len),
        .active    (rx_active),
        .frame_done(frame_done)
    );

    // Standby silences idle reporting unless idle detection is allowed there.
    assign idle_report = idle_hit & ~(standby & ~standby_idle_en);

    assign set_v[IDX_BRK]  = brk_hit;
    assign set_v[IDX_IDLE] = idle_report;
    assign set_v[IDX_EDGE] = fall_evt;
    assign clr_v = {clr_edge, clr_idle, clr_brk};
    assign en_v  = {edge_irq_en, idle_irq_en, brk_irq_en};

    brk_flag_bank #(.N(NFLAG)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_evt(set_v),
        .clr    (clr_v),
        .irq_en (en_v),
        .flag   (flag_v),
        .irq    (irq_v)
    );

    assign brk_flag  = flag_v[IDX_BRK];
    assign idle_flag = flag_v[IDX_IDLE];
    assign edge_flag = flag_v[IDX_EDGE];
    assign brk_irq   = irq_v[IDX_BRK];
    assign idle_irq  = irq_v[IDX_IDLE];
    assign edge_irq  = irq_v[IDX_EDGE];
endmodule

// File: rtl/brk_idle_mon_chk.sv
// Checker for brk_idle_mon: temporal properties on the top-level ports, bound
// into every instance of the top module.
module brk_idle_mon_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_sample,
    input logic rx_invert,
    input logic bit_tick,
    input logic standby,
    input logic standby_idle_en,
    input logic clr_brk,
    input logic edge_irq_en,
    input logic brk_flag,
    input logic idle_flag,
    input logic edge_flag,
    input logic rx_active,
    input logic edge_irq
);
    // R2: a break flag only rises after a low tick.
    p_brk_on_low_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_flag) |-> ($past(bit_tick) && !$past(rx_sample ^ rx_invert)));

    // R4: an idle flag only rises after a high tick.
    p_idle_on_high_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_flag) |-> ($past(bit_tick) && $past(rx_sample ^ rx_invert)));

    // R6: standby without idle detection keeps a clear idle flag clear.
    p_standby_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && !standby_idle_en && !idle_flag) |=> !idle_flag);

    // R7: the active status rises only after the effective line was low.
    p_active_after_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_active) |-> !$past(rx_sample ^ rx_invert));

    // R8: a falling effective line sets the edge flag on the next edge.
    p_edge_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rx_sample ^ rx_invert) && $past(rx_sample ^ rx_invert)) |=> edge_flag);

    // R9: without a clear, a set break flag stays set.
    p_brk_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_flag && !clr_brk) |=> brk_flag);

    // R10: an edge request only appears with its enable and flag.
    p_edge_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(edge_irq) |-> (edge_irq_en && edge_flag));
endmodule

bind brk_idle_mon brk_idle_mon_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_sample      (rx_sample),
    .rx_invert      (rx_invert),
    .bit_tick       (bit_tick),
    .standby        (standby),
    .standby_idle_en(standby_idle_en),
    .clr_brk        (clr_brk),
    .edge_irq_en    (edge_irq_en),
    .brk_flag       (brk_flag),
    .idle_flag      (idle_flag),
    .edge_flag      (edge_flag),
    .rx_active      (rx_active),
    .edge_irq       (edge_irq)
);

// File: tb/brk_idle_mon_bench.sv
// Bench for brk_idle_mon: a behavioural reference model compared on every
// clock, plus directed checks of thresholds, idle variants and flag handling.
module brk_idle_mon_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_sample = 1'b1, bit_tick = 1'b0;
    logic mode_nine = 1'b0, mode_ten = 1'b0, two_stop = 1'b0, brk_long = 1'b0;
    logic idle_after_stop = 1'b0, rx_invert = 1'b0;
    logic standby = 1'b0, standby_idle_en = 1'b0;
    logic brk_irq_en = 1'b0, idle_irq_en = 1'b0, edge_irq_en = 1'b0;
    logic clr_brk = 1'b0, clr_idle = 1'b0, clr_edge = 1'b0;
    logic brk_flag, idle_flag, edge_flag, rx_active, brk_irq, idle_irq, edge_irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brk_idle_mon u_brk_idle_mon (.*);

    // Reference thresholds, taken from the requirement tables.
    function automatic int ref_thr(bit m9, bit m10, bit two, bit lng);
        int k;
        if (m10 && two)              k = 3;
        else if (m10 || (m9 && two)) k = 2;
        else if (m9 || two)          k = 1;
        else                         k = 0;
        if (lng) begin
            case (k) 0: return 11; 1: return 12; 2: return 14; default: return 15; endcase
        end
        case (k) 0: return 10; 1: return 11; 2: return 12; default: return 13; endcase
    endfunction

    function automatic int ref_len(bit m9, bit m10, bit two);
        return 1 + (m10 ? 10 : (m9 ? 9 : 8)) + (two ? 2 : 1);
    endfunction

    // Reference model state.
    int m_low, m_high, m_pos;
    bit m_prev, m_active, m_brk, m_idle, m_edge;

    always @(posedge clk) begin
        bit e, fl, b, i, q;
        int thr, len;
        if (!rst_n) begin
            m_low = 0; m_high = 0; m_pos = 0; m_prev = 1;
            m_active = 0; m_brk = 0; m_idle = 0; m_edge = 0;
        end else begin
            e   = rx_sample ^ rx_invert;
            fl  = m_prev && !e;
            thr = ref_thr(mode_nine, mode_ten, two_stop, brk_long);
            len = ref_len(mode_nine, mode_ten, two_stop);
            b = 0; i = 0;
            q = !idle_after_stop || (m_pos >= len);
            if (bit_tick) begin
                if (!e) begin
                    if (m_low + 1 == thr) b = 1;
                    if (m_low < 31) m_low++;
                    m_high = 0;
                end else begin
                    m_low = 0;
                    if (q) begin
                        if (m_active && m_high + 1 == len) i = 1;
                        if (m_high < 31) m_high++;
                    end
                end
            end
            if (fl && (!m_active || m_pos >= len)) begin
                m_active = 1; m_pos = 0;
            end else if (i) m_active = 0;
            else if (bit_tick && m_active && m_pos < len) m_pos++;
            m_brk  = b | (m_brk & !clr_brk);
            m_idle = (i && !(standby && !standby_idle_en)) | (m_idle & !clr_idle);
            m_edge = fl | (m_edge & !clr_edge);
            m_prev = e;
        end
    end

    task automatic chk(string req, string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, got, exp, $time);
        end
    endtask

    // Compare against the model every clock, one unit after the falling edge.
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R2", "model brk_flag", brk_flag, m_brk);
            chk("R4", "model idle_flag", idle_flag, m_idle);
            chk("R8", "model edge_flag", edge_flag, m_edge);
            chk("R7", "model rx_active", rx_active, m_active);
            chk("R10", "model brk_irq", brk_irq, m_brk & brk_irq_en);
            chk("R10", "model idle_irq", idle_irq, m_idle & idle_irq_en);
            chk("R10", "model edge_irq", edge_irq, m_edge & edge_irq_en);
        end
    end

    // Watchdog ends a hung run as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // One bit time of four clocks, with the tick in the third.
    task automatic send_raw(logic raw);
        @(negedge clk); rx_sample = raw; bit_tick = 1'b0;
        @(negedge clk);
        @(negedge clk); bit_tick = 1'b1;
        @(negedge clk); bit_tick = 1'b0;
        #1;
    endtask

    task automatic send_bit(logic lvl);
        send_raw(lvl ^ rx_invert);
    endtask

    task automatic send_run(logic lvl, int n);
        for (int k = 0; k < n; k++) send_bit(lvl);
    endtask

    task automatic clear_all();
        @(negedge clk); clr_brk = 1; clr_idle = 1; clr_edge = 1;
        @(negedge clk); clr_brk = 0; clr_idle = 0; clr_edge = 0;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11: reset state.
        chk("R11", "reset brk_flag", brk_flag, 1'b0);
        chk("R11", "reset idle_flag", idle_flag, 1'b0);
        chk("R11", "reset edge_flag", edge_flag, 1'b0);
        chk("R11", "reset rx_active", rx_active, 1'b0);
        chk("R11", "reset irqs", brk_irq | idle_irq | edge_irq, 1'b0);

        send_run(1'b1, 3);
        // R2/R3: every table case, both lengths, then R4 idle after the break.
        for (int lg = 0; lg < 2; lg++) begin
            for (int c = 0; c < 5; c++) begin
                int thr, len;
                @(negedge clk);
                brk_long  = lg[0];
                mode_nine = (c == 1 || c == 2);
                mode_ten  = (c >= 3);
                two_stop  = (c == 2 || c == 4);
                thr = ref_thr(mode_nine, mode_ten, two_stop, brk_long);
                len = ref_len(mode_nine, mode_ten, two_stop);
                clear_all();
                send_run(1'b1, 2);
                send_run(1'b0, thr - 1);
                chk(lg ? "R3" : "R2", "brk one bit early", brk_flag, 1'b0);
                send_bit(1'b0);
                chk(lg ? "R3" : "R2", "brk at threshold", brk_flag, 1'b1);
                chk("R8", "edge after fall", edge_flag, 1'b1);
                chk("R7", "active during break", rx_active, 1'b1);
                send_run(1'b1, len - 1);
                chk("R4", "idle one bit early", idle_flag, 1'b0);
                send_bit(1'b1);
                chk("R4", "idle at char length", idle_flag, 1'b1);
                chk("R7", "inactive after idle", rx_active, 1'b0);
            end
        end

        // R5: after-stop counting, 8 data bits, one stop bit (L=10).
        @(negedge clk);
        brk_long = 0; mode_nine = 0; mode_ten = 0; two_stop = 0; idle_after_stop = 1;
        clear_all();
        send_bit(1'b0); send_run(1'b1, 9);
        send_run(1'b1, 9);
        chk("R5", "after-stop idle early", idle_flag, 1'b0);
        send_bit(1'b1);
        chk("R5", "after-stop idle due", idle_flag, 1'b1);

        // R4: after-start counting counts data and stop bits.
        @(negedge clk); idle_after_stop = 0;
        clear_all();
        send_bit(1'b0);
        chk("R7", "active after start", rx_active, 1'b1);
        send_run(1'b1, 9);
        chk("R4", "after-start idle early", idle_flag, 1'b0);
        send_bit(1'b1);
        chk("R4", "after-start idle due", idle_flag, 1'b1);

        // R6: standby suppresses idle unless enabled.
        @(negedge clk); standby = 1; standby_idle_en = 0;
        clear_all();
        send_bit(1'b0); send_run(1'b1, 12);
        chk("R6", "standby idle suppressed", idle_flag, 1'b0);
        chk("R6", "standby still ends active", rx_active, 1'b0);
        @(negedge clk); standby_idle_en = 1;
        send_bit(1'b0); send_run(1'b1, 10);
        chk("R6", "standby idle allowed", idle_flag, 1'b1);
        @(negedge clk); standby = 0; standby_idle_en = 0;

        // R1: inverted line; raw high counts as low.
        @(negedge clk); rx_invert = 1; rx_sample = 1'b0;
        clear_all();
        for (int k = 0; k < 10; k++) send_raw(1'b1);
        chk("R1", "inverted break", brk_flag, 1'b1);
        for (int k = 0; k < 10; k++) send_raw(1'b0);
        chk("R1", "inverted idle", idle_flag, 1'b1);
        @(negedge clk); rx_invert = 0; rx_sample = 1'b1;

        // R9: sticky flags and set beating a simultaneous clear.
        clear_all();
        send_run(1'b1, 2);
        @(negedge clk); rx_sample = 1'b0; clr_edge = 1;
        @(negedge clk); clr_edge = 0;
        #1;
        chk("R9", "set beats clear", edge_flag, 1'b1);
        send_run(1'b0, 3);
        chk("R9", "edge flag sticky", edge_flag, 1'b1);
        @(negedge clk); clr_edge = 1;
        @(negedge clk); clr_edge = 0;
        #1;
        chk("R9", "edge flag cleared", edge_flag, 1'b0);

        // R10: request gating by enable.
        send_run(1'b1, 2); send_bit(1'b0);
        chk("R10", "edge irq disabled", edge_irq, 1'b0);
        @(negedge clk); edge_irq_en = 1; brk_irq_en = 1; idle_irq_en = 1;
        #1;
        chk("R10", "edge irq enabled", edge_irq, 1'b1);
        send_run(1'b0, 10);
        chk("R10", "brk irq enabled", brk_irq, 1'b1);
        send_run(1'b1, 10);
        chk("R10", "idle irq enabled", idle_irq, 1'b1);
        @(negedge clk); idle_irq_en = 0;
        #1;
        chk("R10", "idle irq disabled", idle_irq, 1'b0);

        send_run(1'b1, 2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule